// File: doc/BRIEF.md
# Byte-Store Read-Modify-Write Unit

This unit lets a pipeline perform byte stores against a word-wide data memory that has no byte-enable port and cannot be changed. The memory is single-ported and synchronous. Each access either reads one word, with the data returned on the following cycle, or writes one word. The memory is addressed by the byte address with its low offset bits removed. A byte store reads the word that contains the byte in the cycle it is accepted. On the next cycle the unit inserts the new byte into the matching big-endian lane and writes the full word back. Word loads and word stores pass through with the same timing they would have without the unit.

Because the write-back uses the memory port in the cycle after a byte store, the unit resolves conflicts with the operation that follows. If that operation is a load or a byte store to the same word, it is accepted at once. It takes its base word from an internal copy of the freshly merged word and does not read memory. Any other memory request in that cycle is held for exactly one cycle through a ready signal. The requester raises at most one strobe per cycle. If several are raised, a load takes precedence over a word store, and a word store over a byte store.

Top module: `byte_store_rmw`

## Requirements
- R1: A load accepted in cycle T with no pending merge drives a memory read at word address `req_addr[31:2]` in T. In T+1 it raises `load_valid` for one cycle, with `load_data` equal to the word as written by every operation accepted before it.
- R2: A word store accepted in cycle T writes `req_wdata` unmodified to word `req_addr[31:2]` in T.
- R3: A byte store accepted in cycle T writes back in T+1 to the same word address. Byte offset k (`req_addr[1:0]`) replaces bits [31-8k:24-8k] with `req_wdata[7:0]`: offset 0 is bits [31:24] and offset 3 is bits [7:0]. The other three bytes are preserved.
- R4: `load_valid` is high in exactly the cycles that follow an accepted load; stores never raise it.
- R5: In the cycle after an accepted byte store, `req_ready` is low if a request is present and it is anything other than a same-word load or same-word byte store. The stall lasts exactly one cycle.
- R6: A load to the same word as the byte store accepted one cycle earlier is accepted without a stall. It returns the merged word.
- R7: Back-to-back byte stores to one word are accepted without stalls. The final word contains every stored byte.
- R8: While `rst_n` is low, no request is accepted, the memory port is idle and `load_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_load | input | 1 | Word load request |
| req_wstore | input | 1 | Word store request |
| req_bstore | input | 1 | Byte store request |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Store data; a byte store uses bits [7:0] |
| req_ready | output | 1 | Request accepted this cycle when high |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Load result word |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the read |

## Verification
Suppose the copy of the merged word is stale or the forwarding flag is wrong. A load issued right after a byte store then returns wrong data on the next cycle, and a chained byte store writes back a word that has lost the earlier byte. A lane-decode fault corrupts the neighbouring byte, which shows up as soon as that word is read back. A fault in the pending-write tracking appears in the same cycle as a missing or extra stall on `req_ready`, or as a write-back at the wrong word address.

// File: rtl/rmw_pkg.sv
// Shared definitions for the byte-store read-modify-write unit.
// Assumes requests are decoded into one operation per cycle.
package rmw_pkg;
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_LOAD   = 2'd1,
        OP_WSTORE = 2'd2,
        OP_BSTORE = 2'd3
    } op_e;
endpackage

// File: rtl/rmw_lane_merge.sv
// Inserts one byte into a word at a big-endian lane: lane 0 is the most
// significant byte. Purely combinational; assumes DATA_W is a multiple
// of BYTE_W.
module rmw_lane_merge #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int LANES  = DATA_W / BYTE_W,
    parameter int OFF_W  = $clog2(DATA_W / BYTE_W)
) (
    input  logic [DATA_W-1:0] base_word,
    input  logic [BYTE_W-1:0] new_byte,
    input  logic [OFF_W-1:0]  lane,
    output logic [DATA_W-1:0] merged_word
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int HI = DATA_W - 1 - k * BYTE_W;
        // Select the new byte for the addressed lane, keep the old one otherwise.
        assign merged_word[HI -: BYTE_W] =
            (lane == OFF_W'(k)) ? new_byte : base_word[HI -: BYTE_W];
    end
endmodule

// File: rtl/rmw_hazard.sv
// Decides stall and forwarding for the request in the cycle a byte-store
// write-back holds the memory port. Assumes the write-back stage is at
// most one operation deep.
module rmw_hazard #(
    parameter int WADDR_W = 30
) (
    input  logic               rst_n,
    input  rmw_pkg::op_e       req_op,
    input  logic [WADDR_W-1:0] req_waddr,
    input  logic               wb_bstore,
    input  logic [WADDR_W-1:0] wb_waddr,
    output logic               forward,
    output logic               ready
);
    import rmw_pkg::*;

    logic same_word;
    logic fwd_kind;
    logic stall;

    // Classify the incoming request against the pending write-back.
    always_comb begin
        same_word = wb_bstore && (req_waddr == wb_waddr);
        fwd_kind  = (req_op == OP_LOAD) || (req_op == OP_BSTORE);
        forward   = same_word && fwd_kind;
        stall     = wb_bstore && (req_op != OP_NONE) && !forward;
        ready     = rst_n && !stall;
    end
endmodule

// File: rtl/rmw_port_mux.sv
// Drives the single memory port: a pending write-back wins, otherwise the
// accepted request reads (load, byte store) or writes (word store).
// Forwarded requests never touch memory.
module rmw_port_mux #(
    parameter int DATA_W  = 32,
    parameter int WADDR_W = 30
) (
    input  logic               wb_bstore,
    input  logic [WADDR_W-1:0] wb_waddr,
    input  logic [DATA_W-1:0]  merged_word,
    input  rmw_pkg::op_e       acc_op,
    input  logic               acc_forward,
    input  logic [WADDR_W-1:0] req_waddr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               mem_en,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata
);
    import rmw_pkg::*;

    // Pick the single access the port performs this cycle.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = req_waddr;
        mem_wdata = req_wdata;
        if (wb_bstore) begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = wb_waddr;
            mem_wdata = merged_word;
        end else if (acc_op == OP_WSTORE) begin
            mem_en = 1'b1;
            mem_we = 1'b1;
        end else if ((acc_op == OP_LOAD || acc_op == OP_BSTORE) && !acc_forward) begin
            mem_en = 1'b1;
        end
    end
endmodule

// File: rtl/byte_store_rmw.sv
// Byte-store read-modify-write unit in front of a word-only, single-port,
// synchronous-read memory. Accept stage reads; the following stage merges
// and writes back. Assumes at most one request strobe per cycle (load,
// then word store, then byte store take precedence if not).
module byte_store_rmw #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int BYTE_W  = 8,
    parameter int OFF_W   = $clog2(DATA_W / BYTE_W),
    parameter int WADDR_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_load,
    input  logic               req_wstore,
    input  logic               req_bstore,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               load_valid,
    output logic [DATA_W-1:0]  load_data,
    output logic               mem_en,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);
    import rmw_pkg::*;

    op_e                req_op;
    op_e                acc_op;
    logic [WADDR_W-1:0] req_waddr;
    logic               forward;
    logic               ready;

    op_e                wb_op;
    logic [WADDR_W-1:0] wb_waddr;
    logic [OFF_W-1:0]   wb_lane;
    logic [BYTE_W-1:0]  wb_byte;
    logic               wb_fwd;
    logic [DATA_W-1:0]  fwd_word;
    logic [DATA_W-1:0]  base_word;
    logic [DATA_W-1:0]  merged_word;
    logic               wb_bstore;

    // Decode the request strobes into a single operation.
    always_comb begin
        if (req_load)        req_op = OP_LOAD;
        else if (req_wstore) req_op = OP_WSTORE;
        else if (req_bstore) req_op = OP_BSTORE;
        else                 req_op = OP_NONE;
    end

    assign req_waddr = req_addr[ADDR_W-1:OFF_W];
    assign wb_bstore = (wb_op == OP_BSTORE);
    assign acc_op    = ready ? req_op : OP_NONE;
    assign req_ready = ready;

    rmw_hazard #(.WADDR_W(WADDR_W)) u_hazard (
        .rst_n     (rst_n),
        .req_op    (req_op),
        .req_waddr (req_waddr),
        .wb_bstore (wb_bstore),
        .wb_waddr  (wb_waddr),
        .forward   (forward),
        .ready     (ready)
    );

    // Register the second-stage context of loads and byte stores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_op    <= OP_NONE;
            wb_waddr <= '0;
            wb_lane  <= '0;
            wb_byte  <= '0;
            wb_fwd   <= 1'b0;
        end else begin
            wb_op    <= (acc_op == OP_WSTORE) ? OP_NONE : acc_op;
            wb_waddr <= req_waddr;
            wb_lane  <= req_addr[OFF_W-1:0];
            wb_byte  <= req_wdata[BYTE_W-1:0];
            wb_fwd   <= forward && (acc_op != OP_NONE);
        end
    end

    // The base word comes from memory unless the request was forwarded.
    assign base_word = wb_fwd ? fwd_word : mem_rdata;

    rmw_lane_merge #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_merge (
        .base_word   (base_word),
        .new_byte    (wb_byte),
        .lane        (wb_lane),
        .merged_word (merged_word)
    );

    // Keep the latest merged word for a same-word follower.
    always_ff @(posedge clk) begin
        if (!rst_n)         fwd_word <= '0;
        else if (wb_bstore) fwd_word <= merged_word;
    end

    assign load_valid = (wb_op == OP_LOAD);
    assign load_data  = base_word;

    rmw_port_mux #(.DATA_W(DATA_W), .WADDR_W(WADDR_W)) u_port (
        .wb_bstore   (wb_bstore),
        .wb_waddr    (wb_waddr),
        .merged_word (merged_word),
        .acc_op      (acc_op),
        .acc_forward (forward),
        .req_waddr   (req_waddr),
        .req_wdata   (req_wdata),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata)
    );
endmodule

// File: rtl/byte_store_rmw_checker.sv
// Port-level properties of the byte-store read-modify-write unit.
// Assumes the same strobe precedence as the unit.
module byte_store_rmw_checker #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int OFF_W   = 2,
    parameter int WADDR_W = 30
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_load,
    input logic               req_wstore,
    input logic               req_bstore,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [DATA_W-1:0]  req_wdata,
    input logic               req_ready,
    input logic               load_valid,
    input logic [DATA_W-1:0]  load_data,
    input logic               mem_en,
    input logic               mem_we,
    input logic [WADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0]  mem_wdata
);
    logic acc_ld, acc_ws, acc_bs, fwd_ok;
    logic [WADDR_W-1:0] rwa;

    // Acceptance and forwarding eligibility as seen at the ports.
    always_comb begin
        rwa    = req_addr[ADDR_W-1:OFF_W];
        acc_ld = req_load && req_ready;
        acc_ws = !req_load && req_wstore && req_ready;
        acc_bs = !req_load && !req_wstore && req_bstore && req_ready;
        fwd_ok = req_load || (!req_wstore && req_bstore);
    end

    assert_load_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ld && !mem_we) |-> (mem_en && mem_addr == rwa));

    assert_wstore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ws |-> (mem_en && mem_we && mem_addr == rwa && mem_wdata == req_wdata));

    assert_writeback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_bs |=> (mem_en && mem_we && mem_addr == $past(rwa)));

    assert_valid_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ld |=> load_valid);

    assert_valid_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ld |=> !load_valid);

    assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_bs ##1 ((req_load || req_wstore || req_bstore) &&
                     !(fwd_ok && rwa == $past(rwa)))) |-> !req_ready);

    assert_stall_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    assert_fwd_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ld && mem_we) |=> (load_data == $past(mem_wdata)));

    // Reset quiet state, R8.
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_R8: assert (!req_ready && !mem_en && !load_valid);
        end
    end
endmodule

bind byte_store_rmw byte_store_rmw_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .WADDR_W(WADDR_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .req_load(req_load), .req_wstore(req_wstore),
    .req_bstore(req_bstore), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .load_valid(load_valid), .load_data(load_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/byte_store_rmw_bench.sv
// Bench: behavioural memory, behavioural reference model compared every cycle.
module byte_store_rmw_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_load = 1'b0, req_wstore = 1'b0, req_bstore = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, load_valid, mem_en, mem_we;
    logic [31:0] load_data, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [29:0] mem_addr;

    int errors = 0;
    int checks = 0;

    logic [31:0] mem_arr [16];
    logic [31:0] ref_mem [16];

    // Model state
    logic        exp_lv = 1'b0;
    logic [31:0] exp_ld = '0;
    string       ld_tag = "R1";
    logic        prev_bs = 1'b0;
    logic [29:0] prev_word = '0;
    logic        last_acc = 1'b0;

    always #5 clk = ~clk;

    byte_store_rmw u_byte_store_rmw (
        .clk(clk), .rst_n(rst_n), .req_load(req_load), .req_wstore(req_wstore),
        .req_bstore(req_bstore), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .load_valid(load_valid), .load_data(load_data),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Synchronous word memory: write, or read with data the next cycle.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_arr[mem_addr[3:0]] <= mem_wdata;
            else        mem_rdata <= mem_arr[mem_addr[3:0]];
        end
    end

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] put_byte(input logic [31:0] w,
                                             input logic [1:0] off,
                                             input logic [7:0] b);
        logic [31:0] r;
        r = w;
        r[31 - 8 * off -: 8] = b;
        return r;
    endfunction

    // One cycle: sample 1 ns before the edge, compare, advance the model.
    task automatic cycle();
        logic any, same, ready_e;
        #4;
        check(load_valid == exp_lv, "R4", {31'b0, load_valid}, {31'b0, exp_lv});
        if (exp_lv) check(load_data == exp_ld, ld_tag, load_data, exp_ld);
        any     = req_load || req_wstore || req_bstore;
        same    = prev_bs && (req_addr[31:2] == prev_word);
        ready_e = !(prev_bs && any && !(same && (req_load || req_bstore)));
        check(req_ready == ready_e, "R5", {31'b0, req_ready}, {31'b0, ready_e});
        last_acc = ready_e && any;
        exp_lv   = 1'b0;
        if (last_acc) begin
            if (req_load) begin
                exp_lv = 1'b1;
                exp_ld = ref_mem[req_addr[5:2]];
                ld_tag = same ? "R6" : "R1";
            end else if (req_wstore) begin
                ref_mem[req_addr[5:2]] = req_wdata;
            end else begin
                ref_mem[req_addr[5:2]] = put_byte(ref_mem[req_addr[5:2]],
                                                  req_addr[1:0], req_wdata[7:0]);
            end
        end
        prev_bs   = last_acc && !req_load && !req_wstore && req_bstore;
        prev_word = req_addr[31:2];
        @(negedge clk);
    endtask

    task automatic op(input int kind, input logic [31:0] addr, input logic [31:0] data);
        req_load   = (kind == 0);
        req_wstore = (kind == 1);
        req_bstore = (kind == 2);
        req_addr   = addr;
        req_wdata  = data;
        do cycle(); while (!last_acc);
        req_load = 1'b0; req_wstore = 1'b0; req_bstore = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem_arr[i] = 32'h1000_0000 * (i % 8) + 32'h0011_2233 + 32'h0101_0101 * i;
            ref_mem[i] = mem_arr[i];
        end
        // Reset with a load held: R8
        req_load = 1'b1;
        repeat (3) @(negedge clk);
        #4;
        check(!req_ready, "R8", {31'b0, req_ready}, 32'd0);
        check(!mem_en, "R8", {31'b0, mem_en}, 32'd0);
        check(!load_valid, "R8", {31'b0, load_valid}, 32'd0);
        @(negedge clk);
        req_load = 1'b0;
        rst_n = 1'b1;

        // R1: plain loads back to back
        for (int i = 0; i < 4; i++) op(0, 32'(i * 4), 0);
        idle(1);
        // R3: each lane separately on word 5
        for (int k = 0; k < 4; k++) begin op(2, 32'(20 + k), 32'hA0 + k); idle(1); end
        // R7: back-to-back lanes on word 4
        for (int k = 3; k >= 0; k--) op(2, 32'(16 + k), 32'h50 + k);
        idle(1);
        // R6: byte store then same-word load
        op(2, 32'd25, 32'hFFFF_FF6C); op(0, 32'd24, 0); idle(1);
        // R5: byte store then load of another word
        op(2, 32'd28, 32'h77); op(0, 32'd32, 0); idle(1);
        // R5: byte store then word store to same word
        op(2, 32'd36, 32'h12); op(1, 32'd36, 32'hCAFE_F00D); idle(1);
        // R5: byte store then byte store to another word
        op(2, 32'd43, 32'h9A); op(2, 32'd44, 32'hBC); idle(1);
        // R2: word store then byte store then load, same word
        op(1, 32'd52, 32'h0BAD_BEEF); op(2, 32'd54, 32'h33); op(0, 32'd52, 0);
        // R7 then R6: chain and immediate load
        op(2, 32'd56, 32'h01); op(2, 32'd59, 32'h02); op(0, 32'd56, 0);
        idle(2);
        // Read back every word
        for (int i = 0; i < 16; i++) op(0, 32'(i * 4), 0);
        idle(2);
        for (int i = 0; i < 16; i++) begin
            if (i == 4)      check(mem_arr[i] == ref_mem[i], "R7", mem_arr[i], ref_mem[i]);
            else if (i == 9) check(mem_arr[i] == ref_mem[i], "R2", mem_arr[i], ref_mem[i]);
            else             check(mem_arr[i] == ref_mem[i], "R3", mem_arr[i], ref_mem[i]);
        end
        check(ref_mem[5] == 32'hA0A1_A2A3, "R3", ref_mem[5], 32'hA0A1_A2A3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule